// File: doc/BRIEF.md
# Single-Wire Vehicle Bus Transceiver Mode and Wake Controller

This block is the digital control core of a single-wire vehicle bus transceiver. It takes the settings from the host microcontroller: a standby input, a three-level speed/loop code and the transmit bit. It also takes the received bus level, a local wake pin, a power-on-reset flag and an over-temperature flag. From these it picks one operating mode: normal, high-speed, loop-back, standby, go-to-sleep or sleep. In that mode it drives the bus driver enable, the waveshape bypass, the receive output and the regulator inhibit output.

The regulator inhibit output (`inh_o`, high keeps the external regulator on) stays high in every mode except sleep. A high-to-low edge on the standby input starts a sleep countdown, and `inh_o` drops when the countdown expires. Three events raise it again: sustained bus activity, an edge on the local wake pin, or the standby input going high. A power-on reset forces standby with the regulator on.

An over-temperature condition latches the driver off. The latch is released only by a transmit rising edge that arrives after the die has cooled. The bus level and the wake pin are asynchronous, so each passes through a two-flop synchronizer. All timeouts are counted in clock cycles.

Top module: `vbus_mode_ctrl`

## Requirements
- R1: With `stby_i` high and `por_i` low, `speed_i` selects the mode: 2'b00 gives normal, 2'b01 gives high-speed, and 2'b10 or 2'b11 give loop-back.
- R2: In normal mode, `drv_en_o` equals `tx_i` and `shape_bypass_o` is low. `rx_o` is the inverse of `bus_i` as seen through the two-flop synchronizer, so it is low while the bus is active.
- R3: In high-speed mode, `shape_bypass_o` is high and `drv_en_o` equals `tx_i`. `rx_o` behaves as in normal mode.
- R4: In loop-back mode, `drv_en_o` is low and `rx_o` equals the inverse of `tx_i`. `bus_i` has no effect on `rx_o`.
- R5: With `stby_i` low (standby, go-to-sleep or sleep), `drv_en_o` and `shape_bypass_o` are low, and `rx_o` still reports the inverse of the synchronized bus level.
- R6: A high-to-low edge on `stby_i` keeps `inh_o` high for SLEEP_TMO_CYC clock edges. After that `inh_o` goes low and stays low until a wake event occurs.
- R7: While the block is in go-to-sleep or sleep, a synchronized bus level that stays high for BUS_WAKE_CYC consecutive cycles sets `inh_o` high again. A shorter high pulse leaves `inh_o` low.
- R8: A rising or falling edge on `lwake_i`, after synchronization, sets `inh_o` high again from sleep.
- R9: `inh_o` is high on the cycle after any cycle with `stby_i` high. A later falling edge on `stby_i` restarts the full timeout from zero.
- R10: `por_i` high forces standby: the driver is off and `inh_o` is high on the next cycle, even from sleep.
- R11: While `otemp_i` is high, `drv_en_o` is low. After `otemp_i` returns low, `drv_en_o` stays low until the first low-to-high change of `tx_i`, sampled while `otemp_i` is low.
- R12: During and right after reset, with `bus_i` low: `inh_o`=1, `drv_en_o`=0, `shape_bypass_o`=0 and `rx_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stby_i | input | 1 | Standby control, high enables transmit |
| speed_i | input | 2 | Speed/loop code: 00 low, 01 high, 10/11 float |
| tx_i | input | 1 | Transmit data, high drives the bus active |
| bus_i | input | 1 | Comparator output of bus level, high when active (asynchronous) |
| lwake_i | input | 1 | Local wake pin (asynchronous) |
| por_i | input | 1 | Power-on reset flag |
| otemp_i | input | 1 | Over-temperature flag |
| drv_en_o | output | 1 | Bus driver enable |
| shape_bypass_o | output | 1 | Bypass the output waveshaping |
| rx_o | output | 1 | Receive data, low when the bus is active |
| inh_o | output | 1 | Regulator inhibit, high keeps the regulator on |

## Verification
The bound checker checks the following on every cycle:
- the driver is off in loop-back, in any low-standby mode and during over-temperature;
- the bypass appears only with the high-speed code;
- loop-back reception mirrors the inverse of transmit;
- a high standby input or a power-on reset restores the inhibit output one cycle later;
- the inhibit output never falls unless standby was low.

Several behaviours depend on history, so only the bench scenarios can show them: the exact length of the sleep timeout, its restart, the bus-activity filter that separates short glitches from real wake-ups, wake on both edge polarities, and release of the thermal latch only by a transmit rising edge.

// File: rtl/vbus_pkg.sv
package vbus_pkg;
  typedef enum logic [1:0] {
    MD_NORMAL,
    MD_FAST,
    MD_LOOP,
    MD_STBY
  } op_mode_e;

  typedef enum logic [1:0] {
    PW_ON,
    PW_GTS,
    PW_SLEEP
  } pwr_state_e;

  localparam logic [1:0] SPD_LOW  = 2'b00;
  localparam logic [1:0] SPD_HIGH = 2'b01;
endpackage

// File: rtl/vbus_sync.sv
module vbus_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '0;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/vbus_pwr_ctrl.sv
module vbus_pwr_ctrl
  import vbus_pkg::*;
#(
  parameter int SLEEP_TMO_CYC = 16000,
  parameter int BUS_WAKE_CYC  = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stby_i,
  input  logic por_i,
  input  logic bus_s_i,
  input  logic lw_s_i,
  output logic inh_o
);
  localparam int TW  = $clog2(SLEEP_TMO_CYC + 1);
  localparam int BWW = $clog2(BUS_WAKE_CYC + 1);

  pwr_state_e st, st_nxt;
  logic           stby_q, lw_q;
  logic [TW-1:0]  tmo_cnt;
  logic [BWW-1:0] bw_cnt;
  logic           stby_fall, lw_edge, bus_wake, wake, tmo_done;

  assign stby_fall = stby_q & ~stby_i;
  assign lw_edge   = lw_s_i ^ lw_q;
  assign bus_wake  = (bw_cnt == BWW'(BUS_WAKE_CYC));
  assign wake      = bus_wake | lw_edge;
  assign tmo_done  = (tmo_cnt == TW'(SLEEP_TMO_CYC - 1));

  always_comb begin
    st_nxt = st;
    if (por_i || stby_i) st_nxt = PW_ON;
    else if (stby_fall)  st_nxt = PW_GTS;
    else begin
      case (st)
        PW_GTS:   if (wake) st_nxt = PW_ON; else if (tmo_done) st_nxt = PW_SLEEP;
        PW_SLEEP: if (wake) st_nxt = PW_ON;
        default:  st_nxt = st;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= PW_ON;
      stby_q  <= 1'b0;
      lw_q    <= 1'b0;
      tmo_cnt <= '0;
      bw_cnt  <= '0;
    end else begin
      st     <= st_nxt;
      stby_q <= stby_i;
      lw_q   <= lw_s_i;
      if (stby_fall)        tmo_cnt <= '0;
      else if (st == PW_GTS) tmo_cnt <= tmo_cnt + 1'b1;
      // consecutive-high filter on bus activity
      if (!bus_s_i)      bw_cnt <= '0;
      else if (!bus_wake) bw_cnt <= bw_cnt + 1'b1;
    end
  end

  assign inh_o = (st != PW_SLEEP);
endmodule

// File: rtl/vbus_therm_latch.sv
module vbus_therm_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic otemp_i,
  input  logic tx_i,
  output logic drv_block_o
);
  logic flt_q, tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flt_q <= 1'b0;
      tx_q  <= 1'b0;
    end else begin
      tx_q <= tx_i;
      if (otemp_i) flt_q <= 1'b1;
      else if (flt_q && tx_i && !tx_q) flt_q <= 1'b0;
    end
  end

  assign drv_block_o = flt_q | otemp_i;
endmodule

// File: rtl/vbus_mode_ctrl.sv
module vbus_mode_ctrl
  import vbus_pkg::*;
#(
  parameter int SLEEP_TMO_CYC = 16000,
  parameter int BUS_WAKE_CYC  = 2000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stby_i,
  input  logic [1:0] speed_i,
  input  logic       tx_i,
  input  logic       bus_i,
  input  logic       lwake_i,
  input  logic       por_i,
  input  logic       otemp_i,
  output logic       drv_en_o,
  output logic       shape_bypass_o,
  output logic       rx_o,
  output logic       inh_o
);
  logic [1:0] sync_q;
  logic       bus_s, lw_s, drv_block;
  op_mode_e   mode;

  vbus_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({bus_i, lwake_i}),
    .q_o    (sync_q)
  );
  assign bus_s = sync_q[1];
  assign lw_s  = sync_q[0];

  vbus_pwr_ctrl #(.SLEEP_TMO_CYC(SLEEP_TMO_CYC), .BUS_WAKE_CYC(BUS_WAKE_CYC)) u_pwr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stby_i  (stby_i),
    .por_i   (por_i),
    .bus_s_i (bus_s),
    .lw_s_i  (lw_s),
    .inh_o   (inh_o)
  );

  vbus_therm_latch u_therm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .otemp_i     (otemp_i),
    .tx_i        (tx_i),
    .drv_block_o (drv_block)
  );

  always_comb begin
    if (por_i || !stby_i)       mode = MD_STBY;
    else if (speed_i == SPD_LOW)  mode = MD_NORMAL;
    else if (speed_i == SPD_HIGH) mode = MD_FAST;
    else                          mode = MD_LOOP;
  end

  assign drv_en_o       = (mode == MD_NORMAL || mode == MD_FAST) && tx_i && !drv_block;
  assign shape_bypass_o = (mode == MD_FAST);
  assign rx_o           = (mode == MD_LOOP) ? !tx_i : !bus_s;
endmodule

// File: rtl/vbus_mode_ctrl_chk.sv
module vbus_mode_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       stby_i,
  input logic [1:0] speed_i,
  input logic       tx_i,
  input logic       por_i,
  input logic       otemp_i,
  input logic       drv_en_o,
  input logic       shape_bypass_o,
  input logic       rx_o,
  input logic       inh_o
);
  // R4
  loop_drv_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stby_i && !por_i && speed_i[1]) |-> !drv_en_o);
  // R4
  loop_rx_mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stby_i && !por_i && speed_i[1]) |-> (rx_o == !tx_i));
  // R5
  stby_drv_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stby_i |-> (!drv_en_o && !shape_bypass_o));
  // R3
  bypass_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shape_bypass_o |-> (stby_i && !por_i && speed_i == 2'b01));
  // R11
  otemp_drv_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    otemp_i |-> !drv_en_o);
  // R9
  stby_inh_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stby_i |=> inh_o);
  // R10
  por_inh_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> inh_o);
  // R6
  inh_fall_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(inh_o) |-> (!$past(stby_i) && !$past(por_i)));
endmodule

bind vbus_mode_ctrl vbus_mode_ctrl_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .stby_i         (stby_i),
  .speed_i        (speed_i),
  .tx_i           (tx_i),
  .por_i          (por_i),
  .otemp_i        (otemp_i),
  .drv_en_o       (drv_en_o),
  .shape_bypass_o (shape_bypass_o),
  .rx_o           (rx_o),
  .inh_o          (inh_o)
);

// File: tb/vbus_mode_ctrl_bench.sv
module vbus_mode_ctrl_bench;
  localparam int TMO = 40;
  localparam int BW  = 6;
  localparam int NV  = 10;
  // {stby, speed[1:0], tx, bus, exp_drv, exp_byp, exp_rx}
  localparam logic [7:0] VEC [NV] = '{
    8'b1_00_1_1_1_0_0,  // R2 normal, driving
    8'b1_00_0_0_0_0_1,  // R2 idle bus
    8'b1_00_0_1_0_0_0,  // R2 another node active
    8'b1_01_1_1_1_1_0,  // R3 high-speed
    8'b1_01_0_0_0_1_1,  // R3
    8'b1_10_1_0_0_0_0,  // R4 loop-back rx=~tx
    8'b1_10_0_1_0_0_1,  // R4 bus ignored
    8'b1_11_1_1_0_0_0,  // R1 code 11 is loop-back
    8'b0_00_1_1_0_0_0,  // R5 standby reports bus
    8'b0_01_1_0_0_0_1   // R5
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic stby = 1'b0, tx = 1'b0, bus = 1'b0, lwake = 1'b0, por = 1'b0, otemp = 1'b0;
  logic [1:0] speed = 2'b00;
  logic drv_en, byp, rx, inh;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vbus_mode_ctrl #(.SLEEP_TMO_CYC(TMO), .BUS_WAKE_CYC(BW)) u_vbus_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .stby_i(stby), .speed_i(speed), .tx_i(tx),
    .bus_i(bus), .lwake_i(lwake), .por_i(por), .otemp_i(otemp),
    .drv_en_o(drv_en), .shape_bypass_o(byp), .rx_o(rx), .inh_o(inh)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_sleep();
    stby = 1'b1; cyc(3);
    stby = 1'b0; cyc(TMO + 5);
  endtask

  initial begin
    cyc(3);
    check("R12 inh in reset", inh, 1'b1);
    check("R12 drv in reset", drv_en, 1'b0);
    rst_ni = 1'b1; cyc(2);
    check("R12 inh after reset", inh, 1'b1);
    check("R12 byp after reset", byp, 1'b0);
    check("R12 rx after reset", rx, 1'b1);
    check("R12 drv after reset", drv_en, 1'b0);

    for (int i = 0; i < NV; i++) begin
      {stby, speed, tx, bus} = VEC[i][7:3];
      cyc(4);
      check($sformatf("R1 vec%0d drv", i), drv_en, VEC[i][2]);
      check($sformatf("R1 vec%0d byp", i), byp, VEC[i][1]);
      check($sformatf("R1 vec%0d rx", i), rx, VEC[i][0]);
      check($sformatf("R1 vec%0d inh", i), inh, 1'b1);
    end
    tx = 1'b0; bus = 1'b0; speed = 2'b00;

    // R6 timeout length
    stby = 1'b1; cyc(3);
    stby = 1'b0; cyc(TMO - 3);
    check("R6 inh before timeout", inh, 1'b1);
    cyc(6);
    check("R6 inh after timeout", inh, 1'b0);
    cyc(50);
    check("R6 inh stays low", inh, 1'b0);

    // R7 short bus pulse ignored, long pulse wakes; R5 rx in sleep
    bus = 1'b1; cyc(3);
    check("R5 rx reports bus in sleep", rx, 1'b0);
    cyc(1); bus = 1'b0; cyc(10);
    check("R7 short pulse ignored", inh, 1'b0);
    bus = 1'b1; cyc(BW + 4); bus = 1'b0; cyc(6);
    check("R7 bus activity wakes", inh, 1'b1);

    // R8 local wake, both polarities
    go_sleep();
    check("R8 asleep before rise", inh, 1'b0);
    lwake = 1'b1; cyc(5);
    check("R8 rising wake edge", inh, 1'b1);
    go_sleep();
    check("R8 asleep before fall", inh, 1'b0);
    lwake = 1'b0; cyc(5);
    check("R8 falling wake edge", inh, 1'b1);

    // R9 standby high wakes; abort and restart timeout
    go_sleep();
    stby = 1'b1; cyc(2);
    check("R9 stby high wakes", inh, 1'b1);
    stby = 1'b0; cyc(TMO / 2);
    stby = 1'b1; cyc(2);
    stby = 1'b0; cyc(TMO - 3);
    check("R9 timeout restarted", inh, 1'b1);
    cyc(6);
    check("R9 restarted timeout expires", inh, 1'b0);

    // R10 power-on reset overrides sleep
    por = 1'b1; cyc(1);
    check("R10 por wakes from sleep", inh, 1'b1);
    por = 1'b0; cyc(TMO + 10);
    check("R10 standby holds inh", inh, 1'b1);

    // R11 thermal latch
    stby = 1'b1; speed = 2'b00; tx = 1'b1; cyc(2);
    check("R11 driving before fault", drv_en, 1'b1);
    otemp = 1'b1; cyc(1);
    check("R11 fault blocks driver", drv_en, 1'b0);
    tx = 1'b0; cyc(1); tx = 1'b1; cyc(1);
    check("R11 tx rise during fault ignored", drv_en, 1'b0);
    otemp = 1'b0; cyc(3);
    check("R11 latch holds after cooling", drv_en, 1'b0);
    tx = 1'b0; cyc(2); tx = 1'b1; cyc(1);
    check("R11 tx rising edge releases", drv_en, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule